// File: doc/BRIEF.md
# RTC Control Register and Interrupt Pin Logic

This block sits between the host register bus of a real-time clock and its single interrupt / square-wave pin. It keeps the 8-bit control register, the two alarm flags and the user temperature-conversion request. From these and a few live inputs it decides what the pin does. The pin either carries a 1 Hz square wave or acts as an active-low, open-drain alarm interrupt. It is modelled as a data bit plus an output enable. When the clock runs from its backup cell, the pin floats unless the host has enabled the battery-backed square wave.

The host writes and reads through a one-cycle register bus with no wait states. Address 0 selects the control register and address 1 the status register. The alarm comparators deliver one-cycle match pulses. A half-second tick paces the square wave and the conversion rate limit.

User conversion requests go to the temperature engine over a valid/ready pair. `conv_req_valid` stays high until the engine accepts it with `conv_req_ready`, so the engine may stall for any number of cycles and nothing is lost. Once accepted, the request is in flight until a one-cycle `conv_done` pulse arrives.

Top module: `rtc_ctl_top`

## Requirements
- R1: Control register at address 0 is laid out as bit 7 oscillator-disable, bit 6 battery square-wave enable, bit 5 convert, bits 4:3 spare, bit 2 interrupt mode (1 = alarm interrupt, 0 = square wave), bit 1 alarm-2 enable, bit 0 alarm-1 enable. Spare bits store and read back whatever was written and change nothing else.
- R2: After reset the control register reads 0x04 and the status register reads 0x00. The pin is released (`pin_oe` = 0) and no conversion is requested.
- R3: In interrupt mode on main supply, the pin is driven low (`pin_oe` = 1, `pin_out` = 0) exactly when (alarm-1 flag and alarm-1 enable) or (alarm-2 flag and alarm-2 enable). Otherwise it is released.
- R4: Status register at address 1: bit 0 alarm-1 flag, bit 1 alarm-2 flag, bit 2 conversion busy, other bits 0. A match pulse sets its flag whatever the mode and enable bits are. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A match in the same cycle as a clear wins. The pin releases in the cycle the flag clears.
- R5: In square-wave mode the pin is driven (`pin_oe` = 1) and `pin_out` starts at 0 after reset and toggles on every half-second tick.
- R6: While `on_battery` = 1, the pin is released unless battery square-wave enable = 1 and interrupt mode = 0. In that case the square wave continues.
- R7: `osc_stop` = oscillator-disable AND `on_battery`. While it is high, ticks, match pulses and bus writes are ignored and all register contents stay unchanged. On main supply the bit has no effect.
- R8: Writing 1 to bit 5 sets the convert bit and the busy flag and queues a request. Both read 1 until `conv_done`, then both clear. Writing 0 to bit 5 while a conversion is pending or running has no effect.
- R9: A queued request is presented on `conv_req_valid` only once at least TICKS_PER_SEC ticks have passed since the previous accepted request. Until then it is held. Valid stays high until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| half_sec_tick | input | 1 | One-cycle pulse every half second |
| alarm_hit | input | 2 | Match pulses, bit 0 alarm 1, bit 1 alarm 2 |
| on_battery | input | 1 | Supply below power-fail threshold |
| conv_req_valid | output | 1 | Conversion request to temperature engine |
| conv_req_ready | input | 1 | Engine accepts request |
| conv_done | input | 1 | Conversion and compensation finished |
| osc_stop | output | 1 | Request to halt the oscillator |
| pin_out | output | 1 | Pin data level when driven |
| pin_oe | output | 1 | Pin output enable |

## Verification
A wrong flag or enable state appears on `pin_oe` in the cycle after the bus write or match pulse that caused it. A wrong square-wave phase shows as an inverted `pin_out` after the next tick. A stuck convert or in-flight state is seen on control bit 5 and status bit 2 on the very next read. It also shows as a `conv_req_valid` that rises too early, too late or never, which the rate-limit cases measure in ticks. A leak in the stopped-oscillator freeze shows as a register value or phase that moved when it should have held.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
  localparam int unsigned N_ALM = 2;
  localparam int unsigned BUSY_BIT = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic       osc_dis;
    logic       bat_sqw;
    logic       conv;
    logic [1:0] spare;
    logic       irq_mode;
    logic [N_ALM-1:0] alarm_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{osc_dis: 1'b0, bat_sqw: 1'b0, conv: 1'b0,
                                 spare: 2'b00, irq_mode: 1'b1,
                                 alarm_en: '0};
endpackage

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic [N_ALM-1:0] alarm_hit,
  input  logic             freeze,
  output ctrl_t            ctrl_q,
  output logic [N_ALM-1:0] flag_q
);
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL) && !freeze;
  assign stat_wr = bus_wr && (bus_addr == ADDR_STAT) && !freeze;

  // convert bit is owned by the scheduler; stored copy stays 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_wr) begin
      ctrl_q      <= ctrl_t'(bus_wdata);
      ctrl_q.conv <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_ALM; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (!freeze) begin
        if (alarm_hit[i])                 flag_q[i] <= 1'b1;
        else if (stat_wr && !bus_wdata[i]) flag_q[i] <= 1'b0;
      end
    end

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_hit[i] && !freeze) |=> flag_q[i]);
  end

  assert_frozen_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(ctrl_q) && $stable(flag_q)));
endmodule

// File: rtl/rtc_conv_sched.sv
module rtc_conv_sched #(
  parameter int unsigned TICKS_PER_SEC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic tick_en,
  input  logic conv_req_ready,
  input  logic conv_done,
  output logic conv_req_valid,
  output logic conv_bit
);
  localparam int unsigned CW = $clog2(TICKS_PER_SEC + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(TICKS_PER_SEC);

  logic [CW-1:0] since_q;
  logic pending_q, inflight_q, may_go, accept;

  assign may_go         = (since_q == CNT_FULL);
  assign conv_req_valid = pending_q && may_go;
  assign accept         = conv_req_valid && conv_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= CNT_FULL;
      pending_q  <= 1'b0;
      inflight_q <= 1'b0;
      conv_bit   <= 1'b0;
    end else begin
      if (accept) begin
        pending_q  <= 1'b0;
        inflight_q <= 1'b1;
        since_q    <= '0;
      end else if (tick_en && !may_go) begin
        since_q <= since_q + 1'b1;
      end
      if (set_req && !conv_bit) begin
        conv_bit  <= 1'b1;
        pending_q <= 1'b1;
      end
      if (inflight_q && conv_done) begin
        conv_bit   <= 1'b0;
        inflight_q <= 1'b0;
      end
    end
  end

  assert_conv_clears_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_bit) |-> $past(conv_done));

  assert_one_per_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !conv_req_valid);

  assert_valid_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready) |=> conv_req_valid);
endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
  import rtc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             on_battery,
  input  ctrl_t            ctrl_q,
  input  logic [N_ALM-1:0] flag_q,
  output logic             pin_out,
  output logic             pin_oe
);
  logic phase_q, irq_act, sqw_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (tick_en) phase_q <= !phase_q;
  end

  assign irq_act = |(flag_q & ctrl_q.alarm_en);
  assign sqw_sel = !ctrl_q.irq_mode;

  always_comb begin
    pin_oe  = 1'b0;
    pin_out = 1'b0;
    if (on_battery && !(ctrl_q.bat_sqw && sqw_sel)) begin
      pin_oe = 1'b0;
    end else if (sqw_sel) begin
      pin_oe  = 1'b1;
      pin_out = phase_q;
    end else begin
      pin_oe = irq_act;
    end
  end

  assert_sq_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (phase_q != $past(phase_q)));

  assert_batt_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && !ctrl_q.bat_sqw) |-> !pin_oe);

  assert_irq_active_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && ctrl_q.irq_mode) |-> !pin_out);
endmodule

// File: rtl/rtc_ctl_top.sv
module rtc_ctl_top
  import rtc_ctl_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       half_sec_tick,
  input  logic [1:0] alarm_hit,
  input  logic       on_battery,
  output logic       conv_req_valid,
  input  logic       conv_req_ready,
  input  logic       conv_done,
  output logic       osc_stop,
  output logic       pin_out,
  output logic       pin_oe
);
  ctrl_t            ctrl_q, ctrl_rd;
  logic [N_ALM-1:0] flag_q;
  logic             freeze, tick_en, set_req, conv_bit;
  logic [7:0]       stat_rd;

  assign freeze   = ctrl_q.osc_dis && on_battery;
  assign osc_stop = freeze;
  assign tick_en  = half_sec_tick && !freeze;
  assign set_req  = bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[5] && !freeze;

  rtc_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .alarm_hit(alarm_hit), .freeze(freeze),
    .ctrl_q(ctrl_q), .flag_q(flag_q)
  );

  rtc_conv_sched #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_conv (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .tick_en(tick_en),
    .conv_req_ready(conv_req_ready), .conv_done(conv_done),
    .conv_req_valid(conv_req_valid), .conv_bit(conv_bit)
  );

  rtc_pin_mux u_pin (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .on_battery(on_battery),
    .ctrl_q(ctrl_q), .flag_q(flag_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    ctrl_rd      = ctrl_q;
    ctrl_rd.conv = conv_bit;
    stat_rd      = '0;
    stat_rd[N_ALM-1:0] = flag_q;
    stat_rd[BUSY_BIT]  = conv_bit;
    bus_rdata = (bus_addr == ADDR_CTRL) ? 8'(ctrl_rd) : stat_rd;
  end

  assert_osc_runs_on_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !on_battery |-> !osc_stop);
endmodule

// File: tb/test_rtc_ctl_top.sv
module test_rtc_ctl_top;
  localparam time CLK_PERIOD = 10;
  localparam int  NV = 20;

  typedef struct packed {
    logic       wr;
    logic       addr;
    logic [7:0] wdata;
    logic       tick;
    logic [1:0] hit;
    logic       batt;
    logic       e_oe;
    logic       e_out;
    logic [7:0] e_rd;
  } vec_t;

  // wr addr wdata tick hit batt | oe out rdata
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'h00,1'b0,2'b00,1'b0, 1'b0,1'b0,8'h04},
    '{1'b0,1'b1,8'h00,1'b0,2'b01,1'b0, 1'b0,1'b0,8'h01},
    '{1'b1,1'b0,8'h05,1'b0,2'b00,1'b0, 1'b1,1'b0,8'h05},
    '{1'b1,1'b1,8'hFE,1'b0,2'b00,1'b0, 1'b0,1'b0,8'h00},
    '{1'b0,1'b1,8'h00,1'b0,2'b10,1'b0, 1'b0,1'b0,8'h02},
    '{1'b1,1'b0,8'h07,1'b0,2'b00,1'b0, 1'b1,1'b0,8'h07},
    '{1'b1,1'b0,8'h1F,1'b0,2'b00,1'b0, 1'b1,1'b0,8'h1F},
    '{1'b1,1'b0,8'h00,1'b0,2'b00,1'b0, 1'b1,1'b0,8'h00},
    '{1'b0,1'b0,8'h00,1'b1,2'b00,1'b0, 1'b1,1'b1,8'h00},
    '{1'b0,1'b0,8'h00,1'b1,2'b00,1'b0, 1'b1,1'b0,8'h00},
    '{1'b0,1'b0,8'h00,1'b1,2'b00,1'b1, 1'b0,1'b0,8'h00},
    '{1'b1,1'b0,8'h40,1'b0,2'b00,1'b1, 1'b1,1'b1,8'h40},
    '{1'b0,1'b0,8'h00,1'b1,2'b00,1'b1, 1'b1,1'b0,8'h40},
    '{1'b1,1'b0,8'hC0,1'b0,2'b00,1'b1, 1'b1,1'b0,8'hC0},
    '{1'b0,1'b0,8'h00,1'b1,2'b00,1'b1, 1'b1,1'b0,8'hC0},
    '{1'b0,1'b1,8'h00,1'b0,2'b01,1'b1, 1'b1,1'b0,8'h02},
    '{1'b1,1'b0,8'h00,1'b0,2'b00,1'b1, 1'b1,1'b0,8'hC0},
    '{1'b0,1'b0,8'h00,1'b1,2'b00,1'b0, 1'b1,1'b1,8'hC0},
    '{1'b1,1'b0,8'h06,1'b0,2'b00,1'b0, 1'b1,1'b0,8'h06},
    '{1'b1,1'b1,8'hFD,1'b0,2'b00,1'b0, 1'b0,1'b0,8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       half_sec_tick = 1'b0;
  logic [1:0] alarm_hit = '0;
  logic       on_battery = 1'b0;
  logic       conv_req_valid, conv_req_ready = 1'b0, conv_done = 1'b0;
  logic       osc_stop, pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_ctl_top i_rtc_ctl_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .half_sec_tick(half_sec_tick),
    .alarm_hit(alarm_hit), .on_battery(on_battery),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_done(conv_done), .osc_stop(osc_stop), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, settle
  task automatic step(input logic wr, input logic addr, input logic [7:0] wd,
                      input logic tk, input logic [1:0] hit, input logic batt,
                      input logic rdy, input logic dn);
    @(negedge clk);
    bus_wr = wr; bus_addr = addr; bus_wdata = wd; half_sec_tick = tk;
    alarm_hit = hit; on_battery = batt; conv_req_ready = rdy; conv_done = dn;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_read(input logic addr, input logic batt);
    step(1'b0, addr, 8'h00, 1'b0, 2'b00, batt, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    check("R2 ctrl", {24'h0, bus_rdata}, 32'h04);
    check("R2 oe", {31'h0, pin_oe}, 32'h0);
    check("R2 valid", {31'h0, conv_req_valid}, 32'h0);
    rst_n = 1'b1;
    idle_read(1'b1, 1'b0);
    check("R2 status", {24'h0, bus_rdata}, 32'h00);

    // vector table: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].tick,
           VECS[i].hit, VECS[i].batt, 1'b0, 1'b0);
      check($sformatf("R1/R3-R7 vec%0d", i),
            {22'h0, pin_oe, pin_out, bus_rdata},
            {22'h0, VECS[i].e_oe, VECS[i].e_out, VECS[i].e_rd});
    end

    // R8: conversion request and busy
    step(1'b1, 1'b0, 8'h26, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R8 conv bit set", {24'h0, bus_rdata}, 32'h26);
    check("R8 valid", {31'h0, conv_req_valid}, 32'h1);
    step(1'b0, 1'b1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R9 valid held under back-pressure", {31'h0, conv_req_valid}, 32'h1);
    step(1'b0, 1'b1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    check("R8 busy after accept", {24'h0, bus_rdata}, 32'h04);
    check("R8 valid drops", {31'h0, conv_req_valid}, 32'h0);
    step(1'b1, 1'b0, 8'h06, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R8 write 0 ignored", {24'h0, bus_rdata}, 32'h26);
    step(1'b0, 1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    check("R8 cleared on done", {24'h0, bus_rdata}, 32'h06);
    idle_read(1'b1, 1'b0);
    check("R8 busy cleared", {24'h0, bus_rdata}, 32'h00);

    // R9: rate limit, held until TICKS_PER_SEC ticks since last accept
    step(1'b1, 1'b0, 8'h26, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R9 held early", {31'h0, conv_req_valid}, 32'h0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    check("R9 held after one tick", {31'h0, conv_req_valid}, 32'h0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R9 launched after window", {31'h0, conv_req_valid}, 32'h1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    check("R8 second done", {24'h0, bus_rdata}, 32'h06);

    // R4: set wins over clear, then clear releases pin
    step(1'b1, 1'b0, 8'h05, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 8'hFE, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
    check("R4 set wins", {23'h0, pin_oe, bus_rdata}, {23'h0, 1'b1, 8'h01});
    step(1'b1, 1'b1, 8'hFE, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R4 clear releases", {23'h0, pin_oe, bus_rdata}, {23'h0, 1'b0, 8'h00});

    // R7: oscillator stop only on battery
    step(1'b1, 1'b0, 8'hC0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R7 main supply", {31'h0, osc_stop}, 32'h0);
    idle_read(1'b0, 1'b1);
    check("R7 battery stop", {31'h0, osc_stop}, 32'h1);
    idle_read(1'b0, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule